// File: doc/BRIEF.md
# Sequential Buffer Access Port

This block lets a host CPU reach an on-chip packet buffer RAM through a few registers instead of a full address bus. The RAM is split into several areas, and each area has its own base address and size. To make a transfer, the CPU loads a length in bytes, then issues a command code that picks an area and a direction. After that, each strobe on the 16-bit data port moves exactly one word. An internal word pointer starts at the first word of the chosen area and steps forward by one word on each access.

The length is given in bytes even though data moves in words, so the CPU programs twice the word count. An odd length is rounded up to a whole word. The port gives no random access: to reach a word at a later offset, the CPU must first move every word before it. A wrong length cannot hang the port. Accesses beyond the length, or beyond the end of the area, are dropped. Too few accesses leave the transfer pending until the next command.

For reads, the block fetches the next word from the RAM ahead of time. The word the host is about to consume is therefore already waiting on the read data output.

Top module: `buf_access_port`

## Requirements
- R1: After reset, busy_o, done_o, rdata_o and ram_req_o are all 0.
- R2: A `cnt_wr_i` strobe loads wdata_i[15:0] as a byte length. The transfer that the next command starts covers (length+1)/2 words, rounded down. An odd length therefore moves its last word in full.
- R3: A `cmd_wr_i` strobe takes wdata_i[7:0] as the command code. Bit 7 set means write and bit 7 clear means read. Bits [1:0] select the area. Bits [6:2] must be zero; a code with any of them set is ignored, and the pending transfer carries on unchanged.
- R4: A valid command always starts at word 0 of the selected area. Area i (i = 0..3) holds 16·2^i words, starting at RAM word address 16·(2^i − 1).
- R5: During a write transfer, each `data_wr_i` strobe writes wdata_i to RAM at the area base plus the pointer, then advances the pointer by one word.
- R6: During a read transfer, rdata_o shows the word at the pointer from the second cycle after the command or after a `data_rd_i` strobe. Each `data_rd_i` strobe consumes that word and advances the pointer.
- R7: When the last word of a transfer moves, busy_o falls and done_o rises. done_o stays high until the next valid command.
- R8: Data strobes when no transfer is pending cause no RAM access and leave rdata_o unchanged.
- R9: If fewer words are moved than the length calls for, busy_o stays high and done_o stays low.
- R10: The pointer never runs past the end of the area. A transfer ends at the last word of the area even if the length asks for more.
- R11: A data strobe in the direction opposite to the pending transfer causes no RAM access and does not move the pointer.
- R12: A valid command with a zero length sets done_o at once and makes no RAM access.
- R13: A valid command issued while a transfer is pending drops that transfer and restarts from word 0 of the new area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_wr_i | input | 1 | Load byte length from wdata_i |
| cmd_wr_i | input | 1 | Issue command code from wdata_i[7:0] |
| data_wr_i | input | 1 | Data port write strobe |
| data_rd_i | input | 1 | Data port read strobe (consumes rdata_o) |
| wdata_i | input | 16 | Host write data for length, command and data |
| rdata_o | output | 16 | Word waiting at the read pointer |
| busy_o | output | 1 | Transfer pending |
| done_o | output | 1 | Transfer completed |
| ram_req_o | output | 1 | RAM access request |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | 8 | RAM word address |
| ram_wdata_o | output | 16 | RAM write data |
| ram_rdata_i | input | 16 | RAM read data, one cycle after request |

## Verification
The hardest case to reach is a transfer that ends because the pointer hits the end of the area while the byte length still has words left. This needs long transfers on the largest area, and both ways of ending must then stop any further RAM traffic. Directed cases cover:
- a length above the area size;
- a zero length;
- odd lengths;
- strobes in the wrong direction, an invalid code, and a new command while a transfer is still pending.

Random transfers then draw lengths up to just over twice the area size and access counts around the expected word count. This mixes short, exact and overrun transfers on every area. Written words are compared against a bench copy of the whole RAM, so a write to a wrong address also shows up.

// File: rtl/bap_pkg.sv
`timescale 1ns/1ps
package bap_pkg;
  typedef enum logic {DIR_RD = 1'b0, DIR_WR = 1'b1} dir_e;

  function automatic int unsigned area_words(int unsigned min_w, int unsigned idx);
    return min_w << idx;
  endfunction

  function automatic int unsigned area_base(int unsigned min_w, int unsigned idx);
    return min_w * ((1 << idx) - 1);
  endfunction

  function automatic int unsigned total_words(int unsigned min_w, int unsigned n);
    return min_w * ((1 << n) - 1);
  endfunction
endpackage

// File: rtl/bap_cmd_dec.sv
`timescale 1ns/1ps
module bap_cmd_dec
  import bap_pkg::*;
#(
  parameter int unsigned N_AREA = 4,
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic [CMD_W-1:0] code_i,
  output logic             valid_o,
  output dir_e             dir_o,
  output logic [SEL_W-1:0] area_o
);
  localparam int unsigned DIR_BIT = CMD_W - 1;

  logic in_rng;
  logic pad_zero;

  generate
    if (N_AREA == (1 << SEL_W)) begin : g_full
      assign in_rng = 1'b1;
    end else begin : g_part
      assign in_rng = code_i[SEL_W-1:0] < SEL_W'(N_AREA);
    end
  endgenerate

  assign pad_zero = (code_i[DIR_BIT-1:SEL_W] == '0);
  assign valid_o  = pad_zero & in_rng;
  assign dir_o    = code_i[DIR_BIT] ? DIR_WR : DIR_RD;
  assign area_o   = code_i[SEL_W-1:0];
endmodule

// File: rtl/bap_addr_gen.sv
`timescale 1ns/1ps
module bap_addr_gen
  import bap_pkg::*;
#(
  parameter int unsigned N_AREA    = 4,
  parameter int unsigned MIN_WORDS = 16,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned AW        = 8,
  parameter int unsigned PW        = 7
) (
  input  logic [SEL_W-1:0] area_i,
  input  logic [PW-1:0]    ptr_i,
  output logic [AW-1:0]    addr_o,
  output logic [PW-1:0]    lim_o
);
  logic [AW-1:0] base_tab [N_AREA];
  logic [PW-1:0] lim_tab  [N_AREA];
  logic [AW-1:0] base_sel;

  for (genvar g = 0; g < N_AREA; g++) begin : g_tab
    assign base_tab[g] = AW'(area_base(MIN_WORDS, g));
    assign lim_tab[g]  = PW'(area_words(MIN_WORDS, g) - 1);
  end

  always_comb begin
    base_sel = '0;
    lim_o    = '0;
    for (int i = 0; i < N_AREA; i++) begin
      if (area_i == SEL_W'(i)) begin
        base_sel = base_tab[i];
        lim_o    = lim_tab[i];
      end
    end
  end

  assign addr_o = base_sel + AW'(ptr_i);
endmodule

// File: rtl/bap_xfer_ctl.sv
`timescale 1ns/1ps
module bap_xfer_ctl
  import bap_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 2,
  parameter int unsigned PW    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  dir_e             start_dir_i,
  input  logic [SEL_W-1:0] start_area_i,
  input  logic [CNT_W-1:0] start_cnt_i,
  input  logic             step_i,
  input  logic [PW-1:0]    lim_i,
  output logic [PW-1:0]    ptr_o,
  output logic [SEL_W-1:0] area_o,
  output dir_e             dir_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             last_o
);
  logic [CNT_W-1:0] bcnt_q;
  logic [PW-1:0]    ptr_q;
  logic [SEL_W-1:0] area_q;
  dir_e             dir_q;
  logic             busy_q, done_q;

  // last word: byte budget covers at most one more word, or area end reached
  assign last_o = (bcnt_q <= CNT_W'(2)) || (ptr_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q <= '0;
      ptr_q  <= '0;
      area_q <= '0;
      dir_q  <= DIR_RD;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      bcnt_q <= start_cnt_i;
      ptr_q  <= '0;
      area_q <= start_area_i;
      dir_q  <= start_dir_i;
      busy_q <= (start_cnt_i != '0);
      done_q <= (start_cnt_i == '0);
    end else if (step_i) begin
      bcnt_q <= (bcnt_q > CNT_W'(2)) ? bcnt_q - CNT_W'(2) : '0;
      if (last_o) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        ptr_q <= ptr_q + PW'(1);
      end
    end
  end

  assign ptr_o  = ptr_q;
  assign area_o = area_q;
  assign dir_o  = dir_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/buf_access_port.sv
`timescale 1ns/1ps
module buf_access_port
  import bap_pkg::*;
#(
  parameter int unsigned N_AREA    = 4,
  parameter int unsigned MIN_WORDS = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned CMD_W     = 8,
  localparam int unsigned SEL_W    = (N_AREA > 1) ? $clog2(N_AREA) : 1,
  localparam int unsigned TOTAL    = total_words(MIN_WORDS, N_AREA),
  localparam int unsigned AW       = $clog2(TOTAL),
  localparam int unsigned PW       = $clog2(MIN_WORDS << (N_AREA - 1))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_wr_i,
  input  logic              cmd_wr_i,
  input  logic              data_wr_i,
  input  logic              data_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [AW-1:0]     ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic [CNT_W-1:0]  cnt_q;
  logic              dec_valid;
  dir_e              dec_dir;
  logic [SEL_W-1:0]  dec_area;
  logic              cmd_ok;
  logic              step;
  logic [PW-1:0]     ptr;
  logic [SEL_W-1:0]  area_q;
  dir_e              dir_q;
  logic              busy, done, last;
  logic [SEL_W-1:0]  sel_area;
  logic [PW-1:0]     sel_ptr;
  logic [PW-1:0]     lim;
  logic              rd_issue;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_wr_i) cnt_q <= wdata_i[CNT_W-1:0];
  end

  bap_cmd_dec #(.N_AREA(N_AREA), .CMD_W(CMD_W), .SEL_W(SEL_W)) u_dec (
    .code_i (wdata_i[CMD_W-1:0]),
    .valid_o(dec_valid),
    .dir_o  (dec_dir),
    .area_o (dec_area)
  );

  assign cmd_ok = cmd_wr_i & dec_valid;
  // a command wins over a data strobe in the same cycle
  assign step   = busy & ~cmd_ok & ((dir_q == DIR_WR) ? data_wr_i : data_rd_i);

  bap_xfer_ctl #(.CNT_W(CNT_W), .SEL_W(SEL_W), .PW(PW)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (cmd_ok),
    .start_dir_i (dec_dir),
    .start_area_i(dec_area),
    .start_cnt_i (cnt_q),
    .step_i      (step),
    .lim_i       (lim),
    .ptr_o       (ptr),
    .area_o      (area_q),
    .dir_o       (dir_q),
    .busy_o      (busy),
    .done_o      (done),
    .last_o      (last)
  );

  // address source: word 0 of new area on command, next word on read pop
  always_comb begin
    sel_area = cmd_ok ? dec_area : area_q;
    if (cmd_ok)                       sel_ptr = '0;
    else if (dir_q == DIR_RD && step) sel_ptr = ptr + PW'(1);
    else                              sel_ptr = ptr;
  end

  bap_addr_gen #(
    .N_AREA(N_AREA), .MIN_WORDS(MIN_WORDS), .SEL_W(SEL_W), .AW(AW), .PW(PW)
  ) u_addr (
    .area_i(sel_area),
    .ptr_i (sel_ptr),
    .addr_o(ram_addr_o),
    .lim_o (lim)
  );

  assign rd_issue    = (cmd_ok & (dec_dir == DIR_RD) & (cnt_q != '0))
                     | (step & (dir_q == DIR_RD) & ~last);
  assign ram_we_o    = step & (dir_q == DIR_WR);
  assign ram_req_o   = rd_issue | ram_we_o;
  assign ram_wdata_o = wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_issue;
      if (rvalid_q) rdata_q <= ram_rdata_i;
    end
  end

  assign rdata_o = rdata_q;
  assign busy_o  = busy;
  assign done_o  = done;
endmodule

// File: rtl/buf_access_port_chk.sv
`timescale 1ns/1ps
module buf_access_port_chk #(
  parameter int unsigned AW    = 8,
  parameter int unsigned TOTAL = 240
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cmd_wr_i,
  input logic          data_wr_i,
  input logic          data_rd_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          ram_req_o,
  input logic          ram_we_o,
  input logic [AW-1:0] ram_addr_o
);
  assert_addr_in_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_req_o |-> (int'(ram_addr_o) < int'(TOTAL)));

  assert_busy_done_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cmd_wr_i) |=> done_o);

  assert_write_needs_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (busy_o && data_wr_i));

  assert_we_has_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_req_o);

  assert_pending_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cmd_wr_i && !data_wr_i && !data_rd_i) |=> busy_o);

  assert_busy_fall_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(data_wr_i || data_rd_i || cmd_wr_i));
endmodule

bind buf_access_port buf_access_port_chk #(.AW(AW), .TOTAL(TOTAL)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cmd_wr_i  (cmd_wr_i),
  .data_wr_i (data_wr_i),
  .data_rd_i (data_rd_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .ram_req_o (ram_req_o),
  .ram_we_o  (ram_we_o),
  .ram_addr_o(ram_addr_o)
);

// File: tb/buf_access_port_tb.sv
`timescale 1ns/1ps
module buf_access_port_tb;
  localparam int MINW  = 16;
  localparam int NA    = 4;
  localparam int TOTAL = 240;
  localparam int CYC   = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_wr = 1'b0, cmd_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        busy, done;
  logic        ram_req, ram_we;
  logic [7:0]  ram_addr;
  logic [15:0] ram_wdata;
  logic [15:0] ram_rdata = '0;

  logic [15:0] mem    [TOTAL];
  logic [15:0] shadow [TOTAL];
  int total = 0, bad = 0, req_cnt = 0;

  always #(CYC/2) clk = ~clk;

  buf_access_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_wr_i(cnt_wr), .cmd_wr_i(cmd_wr),
    .data_wr_i(data_wr), .data_rd_i(data_rd), .wdata_i(wdata), .rdata_o(rdata),
    .busy_o(busy), .done_o(done), .ram_req_o(ram_req), .ram_we_o(ram_we),
    .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_req) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        ram_rdata <= mem[ram_addr];
      if (rst_n) req_cnt <= req_cnt + 1;
    end
  end

  function automatic int ebase(int a); return MINW * ((1 << a) - 1); endfunction
  function automatic int esize(int a); return MINW << a; endfunction
  function automatic int ewords(int bytes, int a);
    int w = (bytes + 1) / 2;
    return (w < esize(a)) ? w : esize(a);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cnt(int b);
    @(negedge clk); cnt_wr = 1'b1; wdata = 16'(b);
    @(negedge clk); cnt_wr = 1'b0;
  endtask
  task automatic send_cmd(logic [7:0] c);
    @(negedge clk); cmd_wr = 1'b1; wdata = {8'h00, c};
    @(negedge clk); cmd_wr = 1'b0;
  endtask
  task automatic push(logic [15:0] d);
    @(negedge clk); data_wr = 1'b1; wdata = d;
    @(negedge clk); data_wr = 1'b0;
  endtask
  task automatic pop(output logic [15:0] v);
    @(negedge clk); v = rdata; data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic cmp_mem(string tag);
    int diff = 0;
    for (int i = 0; i < TOTAL; i++) if (mem[i] !== shadow[i]) diff++;
    chk(tag, diff, 0);
  endtask

  // write transfer: R2 R4 R5 R7 R9 R10 R12
  task automatic run_write(int a, int bytes, int nacc);
    int w = ewords(bytes, a);
    int r0;
    wr_cnt(bytes);
    send_cmd(8'h80 | 8'(a));
    r0 = req_cnt;
    for (int k = 0; k < nacc; k++) begin
      logic [15:0] d = 16'($urandom);
      push(d);
      if (k < w) shadow[ebase(a) + k] = d;
    end
    chk("R7 done", int'(done), int'(nacc >= w));
    chk("R9 busy", int'(busy), int'(nacc < w));
    chk("R8 R10 write count", req_cnt - r0, (nacc < w) ? nacc : w);
    cmp_mem("R4 R5 ram contents");
  endtask

  // read transfer: R2 R4 R6 R7 R8 R10
  task automatic run_read(int a, int bytes, int nacc);
    int w = ewords(bytes, a);
    int r0;
    logic [15:0] v, lastw;
    wr_cnt(bytes);
    send_cmd(8'(a));
    r0 = req_cnt;
    lastw = rdata;
    for (int k = 0; k < nacc; k++) begin
      pop(v);
      if (k < w) begin
        chk("R6 read word", int'(v), int'(shadow[ebase(a) + k]));
        lastw = v;
      end else begin
        chk("R8 rdata held", int'(v), int'(lastw));
      end
    end
    chk("R7 done", int'(done), int'(nacc >= w));
    chk("R9 busy", int'(busy), int'(nacc < w));
    chk("R8 read count", req_cnt - r0, (w == 0) ? 0 : ((nacc < w - 1) ? nacc : w - 1));
  endtask

  initial begin
    #(CYC * 190000);
    total++; bad++;
    $display("FAIL R1 watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0;
    logic [15:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < TOTAL; i++) begin
      mem[i]    = 16'(i * 37 + 5);
      shadow[i] = 16'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 rdata", int'(rdata), 0);
    chk("R1 ram_req", int'(ram_req), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 odd length, R4 area 0
    run_write(0, 5, 5);
    // R10 length beyond area size
    run_write(0, 100, 20);
    run_write(3, 300, 130);
    // R12 zero length
    run_write(2, 0, 2);
    // R9 short transfer
    run_write(1, 8, 2);
    // R11 wrong-direction strobe while write pending
    r0 = req_cnt;
    pop(d);
    chk("R11 no ram access", req_cnt - r0, 0);
    chk("R11 still busy", int'(busy), 1);
    // R3 invalid code ignored, transfer continues at pointer 2
    send_cmd(8'h84);
    chk("R3 still busy", int'(busy), 1);
    d = 16'hbeef;
    push(d);
    shadow[ebase(1) + 2] = d;
    cmp_mem("R3 R11 pointer unmoved");
    // R13 restart on new valid command while pending
    wr_cnt(4);
    send_cmd(8'h83);
    d = 16'h1357;
    push(d);
    shadow[ebase(3)] = d;
    cmp_mem("R13 restart at word 0");
    chk("R13 busy", int'(busy), 1);
    // R6 reads, restarting each time at word 0 (R4)
    run_read(1, 7, 6);
    run_read(1, 3, 1);
    run_read(0, 40, 18);
    run_read(2, 0, 1);
    // R8 strobes with nothing pending
    r0 = req_cnt;
    d = rdata;
    push(16'h5555);
    pop(d);
    chk("R8 idle no ram", req_cnt - r0, 0);
    chk("R8 idle rdata", int'(rdata), int'(d));

    for (int it = 0; it < 40; it++) begin
      int a = int'($urandom_range(NA - 1, 0));
      int b = int'($urandom_range(2 * esize(a) + 6, 0));
      int w = ewords(b, a);
      int n = w + int'($urandom_range(3, 0)) - 1;
      if (n < 0) n = 0;
      if ($urandom_range(1, 0) == 1) run_write(a, b, n);
      else                           run_read(a, b, n);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule